// File: doc/BRIEF.md
# PHY Register Access Bridge

This block is a single 32-bit control/status word through which host software reaches a small bank of 8-bit registers inside an attached PHY. Software writes the word with a target register address, write data and one of two request bits (read or write). The bridge then offers the operation to the PHY on a valid/ready request channel. The request bit reads back as 1 while the request is waiting and clears itself once the PHY has taken it.

Register transfers that come back from the PHY arrive on a one-cycle response strobe carrying an address and a data byte. The bridge loads both into read-only fields of the word and raises a completion flag. Software can therefore poll the word until the flag is set. The returned address is kept apart from the requested one, because the PHY may report a different register from the one that was asked for.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset the word `host_rdata` reads 0x00000000 and `req_valid` is low.
- R2: A host write with bit 15 set and bit 14 clear, made while no request is pending, starts a read. From the next cycle `req_valid` is 1, `req_is_write` is 0, `req_addr` equals bits 11:8 of the written word, `req_data` is 0 (the write byte is ignored), and bit 15 reads 1.
- R3: A host write with bit 14 set and bit 15 clear, made while no request is pending, starts a write. From the next cycle `req_valid` is 1, `req_is_write` is 1, `req_addr` equals bits 11:8, `req_data` equals bits 7:0, and bit 14 reads 1.
- R4: While `req_valid` is high and `req_ready` is low, the request and its fields hold steady. In the cycle after `req_valid` and `req_ready` are both high, `req_valid` is low and bits 15 and 14 read 0.
- R5: When a request starts (R2 or R3), the completion flag in bit 31 reads 0 from the next cycle.
- R6: A cycle with `rsp_valid` high sets bit 31 and loads bits 27:24 with `rsp_addr` and bits 23:16 with `rsp_data` on the next cycle. This happens even when the returned address differs from the requested address in bits 11:8.
- R7: A host write with bits 15 and 14 both set raises no request, and both bits read 0. Bits 11:8 and 7:0 still take the written values, and bit 31 is left unchanged.
- R8: A host write made while a request is pending has no effect on any field.
- R9: Bits 30:28 and 13:12 always read 0, whatever is written.
- R10: A host write made while no request is pending loads bits 11:8 and 7:0 from the written word, whether or not it carries a request bit.
- R11: If a request starts in the same cycle as a response arrives, bit 31 reads 0 afterwards, and the response address and data are still loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| host_we | input | 1 | Host write strobe for the control word |
| host_wdata | input | 32 | Value written by the host |
| host_rdata | output | 32 | Current value of the control word |
| req_valid | output | 1 | A PHY request is being offered |
| req_ready | input | 1 | The PHY accepts the offered request |
| req_is_write | output | 1 | 1 for a write operation, 0 for a read |
| req_addr | output | 4 | PHY register address |
| req_data | output | 8 | Write byte; 0 on reads |
| rsp_valid | input | 1 | A register transfer is returned from the PHY |
| rsp_addr | input | 4 | Address of the returned register |
| rsp_data | input | 8 | Contents of the returned register |

## Verification
The bound checker watches a set of properties on every cycle. It checks that a stalled request stays stable, that the valid signal drops after a handshake, and that read requests carry zero data. It also checks that the reserved bits stay zero, that a response loads the received fields and sets the flag, that a starting request clears the flag, and that host writes made while a request is pending do not disturb the target fields. Other behaviour can only be shown by the bench's scenarios: the reset image, the exact decode of the illegal both-bits pattern, and the same-cycle collision of a request start with a response. The bench also runs a long random exchange with a behavioural PHY that answers reads after a variable delay, sometimes with a different address.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 8;
  // bit positions inside the host-visible word
  localparam int unsigned POS_DONE = 31;
  localparam int unsigned POS_RXA  = 24;
  localparam int unsigned POS_RXD  = 16;
  localparam int unsigned POS_RD   = 15;
  localparam int unsigned POS_WR   = 14;
  localparam int unsigned POS_TA   = 8;
  localparam int unsigned POS_TD   = 0;
endpackage

// File: rtl/phy_bridge_rst_sync.sv
module phy_bridge_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/phy_bridge_cmd.sv
module phy_bridge_cmd
  import phy_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_rd_bit,
  input  logic              host_wr_bit,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              req_ready,
  output logic              req_valid,
  output logic              req_is_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              start,
  output logic              rd_pend,
  output logic              wr_pend,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data
);
  logic              rd_q, wr_q, rd_d, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              busy, accept, sent, upd_en;

  always_comb begin
    busy   = rd_q | wr_q;
    accept = host_we & ~busy;
    sent   = busy & req_ready;
    upd_en = accept | sent;
    rd_d   = rd_q;
    wr_d   = wr_q;
    addr_d = addr_q;
    data_d = data_q;
    if (accept) begin
      addr_d = host_addr;
      data_d = host_data;
      rd_d   = host_rd_bit & ~host_wr_bit;
      wr_d   = host_wr_bit & ~host_rd_bit;
    end else if (sent) begin
      rd_d = 1'b0;
      wr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (upd_en) begin
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign start        = accept & (host_rd_bit ^ host_wr_bit);
  assign req_valid    = busy;
  assign req_is_write = wr_q;
  assign req_addr     = addr_q;
  assign req_data     = wr_q ? data_q : '0;
  assign rd_pend      = rd_q;
  assign wr_pend      = wr_q;
  assign tgt_addr     = addr_q;
  assign tgt_data     = data_q;
endmodule

// File: rtl/phy_bridge_rsp.sv
module phy_bridge_rsp
  import phy_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rsp_valid,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              done,
  output logic [ADDR_W-1:0] rx_addr,
  output logic [DATA_W-1:0] rx_data
);
  logic              done_q, done_d, done_en;
  logic [ADDR_W-1:0] rxa_q;
  logic [DATA_W-1:0] rxd_q;

  always_comb begin
    done_en = start | rsp_valid;
    // a starting request outranks a returning transfer
    done_d  = start ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       done_q <= 1'b0;
    else if (done_en) done_q <= done_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxa_q <= '0;
      rxd_q <= '0;
    end else if (rsp_valid) begin
      rxa_q <= rsp_addr;
      rxd_q <= rsp_data;
    end
  end

  assign done    = done_q;
  assign rx_addr = rxa_q;
  assign rx_data = rxd_q;
endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge
  import phy_bridge_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_is_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  input  logic              rsp_valid,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [DATA_W-1:0] rsp_data
);
  logic              rst_sync_n;
  logic              start, rd_pend, wr_pend, done;
  logic [ADDR_W-1:0] tgt_addr, rx_addr;
  logic [DATA_W-1:0] tgt_data, rx_data;
  logic              unused_wbits;

  assign unused_wbits = ^{host_wdata[WORD_W-1:POS_RXA], host_wdata[POS_RXD +: DATA_W],
                          host_wdata[POS_WR-1:POS_TA+ADDR_W]};

  phy_bridge_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  phy_bridge_cmd u_cmd (
    .clk(clk), .rst_n(rst_sync_n),
    .host_we(host_we),
    .host_rd_bit(host_wdata[POS_RD]),
    .host_wr_bit(host_wdata[POS_WR]),
    .host_addr(host_wdata[POS_TA +: ADDR_W]),
    .host_data(host_wdata[POS_TD +: DATA_W]),
    .req_ready(req_ready), .req_valid(req_valid), .req_is_write(req_is_write),
    .req_addr(req_addr), .req_data(req_data), .start(start),
    .rd_pend(rd_pend), .wr_pend(wr_pend), .tgt_addr(tgt_addr), .tgt_data(tgt_data)
  );

  phy_bridge_rsp u_rsp (
    .clk(clk), .rst_n(rst_sync_n), .start(start),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .done(done), .rx_addr(rx_addr), .rx_data(rx_data)
  );

  always_comb begin
    host_rdata                      = '0;
    host_rdata[POS_DONE]            = done;
    host_rdata[POS_RXA +: ADDR_W]   = rx_addr;
    host_rdata[POS_RXD +: DATA_W]   = rx_data;
    host_rdata[POS_RD]              = rd_pend;
    host_rdata[POS_WR]              = wr_pend;
    host_rdata[POS_TA +: ADDR_W]    = tgt_addr;
    host_rdata[POS_TD +: DATA_W]    = tgt_data;
  end
endmodule

// File: rtl/phy_reg_bridge_chk.sv
module phy_reg_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic [31:0] host_wdata,
  input logic [31:0] host_rdata,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_is_write,
  input logic [3:0]  req_addr,
  input logic [7:0]  req_data,
  input logic        rsp_valid,
  input logic [3:0]  rsp_addr,
  input logic [7:0]  rsp_data
);
  logic new_req;
  assign new_req = host_we & ~req_valid & (host_wdata[15] ^ host_wdata[14]);

  a_r4_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_is_write) && $stable(req_addr) && $stable(req_data));

  a_r4_drop_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid && host_rdata[15:14] == 2'b00);

  a_r2_read_carries_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_is_write |-> req_data == 8'h00);

  a_r5_start_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    new_req |=> !host_rdata[31] && req_valid);

  a_r6_response_loads: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> host_rdata[27:24] == $past(rsp_addr) && host_rdata[23:16] == $past(rsp_data));

  a_r6_response_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !new_req |=> host_rdata[31]);

  a_r8_pending_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && host_we |=> $stable(host_rdata[11:0]));

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[30:28] == 3'b000 && host_rdata[13:12] == 2'b00);
endmodule

bind phy_reg_bridge phy_reg_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .host_we(host_we), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .req_valid(req_valid), .req_ready(req_ready),
  .req_is_write(req_is_write), .req_addr(req_addr), .req_data(req_data),
  .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
);

// File: tb/phy_reg_bridge_tb.sv
`timescale 1ns/1ps
module phy_reg_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        req_valid, req_ready, req_is_write;
  logic [3:0]  req_addr;
  logic [7:0]  req_data;
  logic        rsp_valid;
  logic [3:0]  rsp_addr;
  logic [7:0]  rsp_data;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model;

  always #2 clk = ~clk;

  phy_reg_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_write(req_is_write), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
  );

  // expected next word, from the requirements
  function automatic logic [31:0] next_word(logic [31:0] w, logic we, logic [31:0] wd,
                                            logic rdy, logic rv, logic [3:0] ra, logic [7:0] rd);
    logic [31:0] n = w;
    logic pend = w[15] | w[14];
    if (we && !pend) begin
      n[11:0] = wd[11:0];
      n[15]   = wd[15] & ~wd[14];
      n[14]   = wd[14] & ~wd[15];
    end else if (pend && rdy) begin
      n[15:14] = 2'b00;
    end
    if (rv) begin
      n[31] = 1'b1; n[27:24] = ra; n[23:16] = rd;
    end
    if (we && !pend && (wd[15] ^ wd[14])) n[31] = 1'b0;
    return n;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs(string tag);
    logic pend = model[15] | model[14];
    check(tag, "word", host_rdata, model);
    check(tag, "req_valid", {31'd0, req_valid}, {31'd0, pend});
    if (pend) begin
      check(tag, "req_is_write", {31'd0, req_is_write}, {31'd0, model[14]});
      check(tag, "req_addr", {28'd0, req_addr}, {28'd0, model[11:8]});
      check(tag, "req_data", {24'd0, req_data}, {24'd0, model[14] ? model[7:0] : 8'h00});
    end
  endtask

  // inputs applied at a falling edge, outputs checked at the next one
  task automatic cyc(string tag, logic we, logic [31:0] wd, logic rdy,
                     logic rv, logic [3:0] ra, logic [7:0] rd);
    host_we = we; host_wdata = wd; req_ready = rdy;
    rsp_valid = rv; rsp_addr = ra; rsp_data = rd;
    model = next_word(model, we, wd, rdy, rv, ra, rd);
    @(posedge clk); @(negedge clk);
    check_outputs(tag);
  endtask

  task automatic idle(string tag, logic rdy);
    cyc(tag, 1'b0, 32'h0, rdy, 1'b0, 4'h0, 8'h00);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int countdown;
    logic [3:0] pend_addr;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; host_we = 1'b0; host_wdata = '0; req_ready = 1'b0;
    rsp_valid = 1'b0; rsp_addr = '0; rsp_data = '0;
    model = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_outputs("R1");

    // R10: plain configuration write, no request bit
    cyc("R10", 1'b1, 32'h0000_0A5C, 1'b0, 1'b0, 4'h0, 8'h00);
    // R2: read of register 3, write byte must not reach the PHY
    cyc("R2", 1'b1, 32'h0000_83FF, 1'b0, 1'b0, 4'h0, 8'h00);
    // R4: stall two cycles, then handshake
    idle("R4", 1'b0);
    idle("R4", 1'b0);
    idle("R4", 1'b1);
    // R6: answer carries another address than was requested
    cyc("R6", 1'b0, 32'h0, 1'b0, 1'b1, 4'h7, 8'h3C);
    // R3 / R5: write request clears the flag
    cyc("R5", 1'b1, 32'h0000_459A, 1'b0, 1'b0, 4'h0, 8'h00);
    // R8: writes while pending are ignored
    cyc("R8", 1'b1, 32'hFFFF_8FFF, 1'b0, 1'b0, 4'h0, 8'h00);
    cyc("R8", 1'b1, 32'h0000_0000, 1'b0, 1'b0, 4'h0, 8'h00);
    idle("R3", 1'b1);
    // flag set again, then R7: both bits leave the flag alone
    cyc("R6", 1'b0, 32'h0, 1'b0, 1'b1, 4'h2, 8'hE1);
    cyc("R7", 1'b1, 32'h0000_C211, 1'b1, 1'b0, 4'h0, 8'h00);
    idle("R7", 1'b1);
    // R9: all ones written
    cyc("R9", 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 4'h0, 8'h00);
    // R11: request start collides with a response
    cyc("R11", 1'b1, 32'h0000_8600, 1'b0, 1'b1, 4'h9, 8'h77);
    idle("R11", 1'b1);

    // random traffic with a behavioural PHY answering reads after a delay
    countdown = 0; pend_addr = 4'h0;
    for (int i = 0; i < 4000; i++) begin
      logic we, rdy, rv;
      logic [31:0] wd;
      logic [3:0] ra;
      logic [7:0] rd;
      logic pend = model[15] | model[14];
      we  = ($urandom % 4) == 0;
      wd  = $urandom;
      if (($urandom % 8) != 0) wd[15:14] = ($urandom % 2) ? 2'b10 : 2'b01;
      rdy = ($urandom % 3) != 0;
      rv  = 1'b0; ra = 4'h0; rd = 8'h00;
      if (countdown == 1) begin
        rv = 1'b1;
        ra = (($urandom % 5) == 0) ? 4'($urandom) : pend_addr;
        rd = {ra, ra} ^ 8'h5A;
      end else if (($urandom % 40) == 0) begin
        rv = 1'b1; ra = 4'($urandom); rd = 8'($urandom);
      end
      if (countdown > 0) countdown--;
      if (pend && rdy && model[15] && countdown == 0) begin
        countdown = 2 + ($urandom % 4);
        pend_addr = model[11:8];
      end
      cyc("R4", we, wd, rdy, rv, ra, rd);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule